// File: doc/BRIEF.md
# Shift-Subtract Remainder Unit

This block returns the remainder of an unsigned dividend divided by an unsigned divisor. It uses only an adder/subtractor, single-bit shifts of the divisor and a small up/down counter. A start pulse loads both operands. The divisor is first shifted left until its top bit is set, and a counter tracks each shift. Then a trial subtraction runs at every shift position, from the highest to the lowest. A negative trial result is undone by adding the divisor back. Between positions the divisor moves right by one and the counter steps down. When the counter reaches zero after a subtract/restore step, the remainder is final. By then the divisor register again holds its loaded value.

The result appears on `remainder` in the same cycle that `done` is high for one cycle. It then holds until the next accepted start. A start that arrives while a computation is in progress is ignored. A zero divisor does not normalize: the unit finishes at once and returns the dividend unchanged.

Top module: `shiftsub_rem`

## Requirements
- R1: After reset, `done` is 0 and `remainder` is 0.
- R2: For a nonzero divisor, `remainder` equals dividend mod divisor, with both operands unsigned, when `done` is high.
- R3: The divisor is shifted left once per cycle until its most significant bit is 1, and each shift is counted. With k leading zeros in the divisor, `done` is first high in the cycle after clock edge 3k+3, where the edge that samples `start` counts as edge 0. At that point the divisor register holds the loaded divisor again and the counter is zero.
- R4: A trial subtraction that leaves the 9-bit working dividend negative (bit 8 set) is undone by adding the divisor back. The working dividend is never negative when a step completes.
- R5: `done` is high for exactly one cycle per accepted start.
- R6: `remainder` holds its value from the `done` cycle until the next accepted start, even if the operand inputs change.
- R7: While a computation is in progress, `start` and changes on the operand inputs have no effect on the result or its timing.
- R8: A zero divisor gives `remainder` equal to the dividend, with `done` high after edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation when idle |
| dividend | input | 8 | Unsigned dividend, sampled at start |
| divisor | input | 8 | Unsigned divisor, sampled at start |
| remainder | output | 8 | Result, valid while done is high and held afterward |
| done | output | 1 | One-cycle pulse when the result is valid |

## Verification
The restoring add and the divisor right shift with counter decrement happen in the same cycle. The add must use the divisor value from before the shift, while the register changes under it. This overlap is provoked by divisors with many leading zeros set against dividends that make the upper trial subtractions go negative, for example divisor 1, 3 or 5 against small or awkward dividends. The result is judged by exact remainders for every nonzero divisor and by the 3k+3 latency. A wrong shift/add ordering corrupts the value, and a missed or extra shift moves the `done` cycle.

// File: rtl/shiftsub_pkg.sv
package shiftsub_pkg;

  // Strobes from control to datapath, one microinstruction per cycle
  typedef struct packed {
    logic load;      // capture operands, clear counter
    logic shiftL;    // divisor << 1, counter up
    logic shiftR;    // divisor >> 1, counter down
    logic subtract;  // working dividend -= divisor
    logic restore;   // working dividend += divisor
    logic capture;   // latch final remainder
  } dpCtrl_t;

  // Status flags returned by the datapath
  typedef struct packed {
    logic dvsMsb;     // normalized divisor top bit
    logic dvdNeg;     // sign of working dividend
    logic cntZero;    // shift counter is zero
    logic dvsInZero;  // divisor input is zero
  } dpStat_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_NORM,
    S_SUB,
    S_FIX,
    S_DONE
  } ctrlState_t;

endpackage

// File: rtl/shiftsub_cnt.sv
module shiftsub_cnt #(
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic up,
  input  logic down,
  output logic isZero
);
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      count <= '0;
    else if (clear) count <= '0;
    else if (up)    count <= count + 1'b1;
    else if (down)  count <= count - 1'b1;
  end

  assign isZero = (count == '0);
endmodule

// File: rtl/shiftsub_dp.sv
module shiftsub_dp
  import shiftsub_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output dpStat_t           stat,
  output logic [DATA_W-1:0] remainder,
  output logic [DATA_W-1:0] dvsReg,
  output logic              cntZero
);
  localparam int DVD_W = DATA_W + 1;

  logic [DVD_W-1:0]  dvdQ;
  logic [DVD_W-1:0]  aluB;
  logic [DVD_W-1:0]  aluOut;
  logic [DATA_W-1:0] dvsQ;
  logic [DATA_W-1:0] remQ;

  // Shared adder/subtractor; divisor zero-extended into the sign position
  always_comb begin
    aluB   = {1'b0, dvsQ};
    aluOut = ctl.subtract ? (dvdQ - aluB) : (dvdQ + aluB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dvdQ <= '0;
      dvsQ <= '0;
      remQ <= '0;
    end else begin
      if (ctl.load) begin
        dvdQ <= {1'b0, dividend};
        dvsQ <= divisor;
      end else begin
        if (ctl.subtract || ctl.restore) dvdQ <= aluOut;
        if (ctl.shiftL)      dvsQ <= {dvsQ[DATA_W-2:0], 1'b0};
        else if (ctl.shiftR) dvsQ <= {1'b0, dvsQ[DATA_W-1:1]};
      end
      if (ctl.capture)
        remQ <= ctl.restore ? aluOut[DATA_W-1:0] : dvdQ[DATA_W-1:0];
    end
  end

  shiftsub_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rstN  (rstN),
    .clear (ctl.load),
    .up    (ctl.shiftL),
    .down  (ctl.shiftR),
    .isZero(cntZero)
  );

  always_comb begin
    stat.dvsMsb    = dvsQ[DATA_W-1];
    stat.dvdNeg    = dvdQ[DVD_W-1];
    stat.cntZero   = cntZero;
    stat.dvsInZero = (divisor == '0);
  end

  assign remainder = remQ;
  assign dvsReg    = dvsQ;
endmodule

// File: rtl/shiftsub_ctrl.sv
module shiftsub_ctrl
  import shiftsub_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    done,
  output logic    idle
);
  ctrlState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          ctl.load  = 1'b1;
          stateNext = stat.dvsInZero ? S_FIX : S_NORM;
        end
      end
      S_NORM: begin
        if (stat.dvsMsb) stateNext = S_SUB;
        else             ctl.shiftL = 1'b1;
      end
      S_SUB: begin
        ctl.subtract = 1'b1;
        stateNext    = S_FIX;
      end
      S_FIX: begin
        ctl.restore = stat.dvdNeg;
        if (stat.cntZero) begin
          ctl.capture = 1'b1;
          stateNext   = S_DONE;
        end else begin
          ctl.shiftR = 1'b1;
          stateNext  = S_SUB;
        end
      end
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign done = (state == S_DONE);
  assign idle = (state == S_IDLE);
endmodule

// File: rtl/shiftsub_rem.sv
module shiftsub_rem
  import shiftsub_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic [DATA_W-1:0] remainder,
  output logic              done
);
  localparam int CNT_W = $clog2(DATA_W);

  dpCtrl_t           ctl;
  dpStat_t           stat;
  logic              fsmIdle;
  logic              cntZero;
  logic [DATA_W-1:0] dvsReg;

  shiftsub_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .stat (stat),
    .ctl  (ctl),
    .done (done),
    .idle (fsmIdle)
  );

  shiftsub_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .dividend (dividend),
    .divisor  (divisor),
    .stat     (stat),
    .remainder(remainder),
    .dvsReg   (dvsReg),
    .cntZero  (cntZero)
  );
endmodule

// File: rtl/shiftsub_rem_chk.sv
module shiftsub_rem_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [DATA_W-1:0] divisor,
  input logic [DATA_W-1:0] remainder,
  input logic              done,
  input logic              fsmIdle,
  input logic [DATA_W-1:0] dvsReg,
  input logic              cntZero,
  input logic              dvdNeg
);
  logic [DATA_W-1:0] origDvs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  origDvs <= '0;
    else if (start && fsmIdle)  origDvs <= divisor;
  end

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r6_rem_hold: assert property (@(posedge clk) disable iff (!rstN)
    done |=> $stable(remainder));

  a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (!rstN)
    (done && origDvs != '0) |-> (remainder < origDvs));

  a_r3_divisor_restored: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (dvsReg == origDvs));

  a_r3_counter_cleared: assert property (@(posedge clk) disable iff (!rstN)
    done |-> cntZero);

  a_r4_not_negative: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !dvdNeg);

  a_r7_no_done_when_idle_start: assert property (@(posedge clk) disable iff (!rstN)
    (start && fsmIdle) |=> !done || (origDvs == '0));
endmodule

bind shiftsub_rem shiftsub_rem_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .divisor  (divisor),
  .remainder(remainder),
  .done     (done),
  .fsmIdle  (fsmIdle),
  .dvsReg   (dvsReg),
  .cntZero  (cntZero),
  .dvdNeg   (stat.dvdNeg)
);

// File: tb/shiftsub_rem_bench.sv
module shiftsub_rem_bench;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [DATA_W-1:0] dividend = '0;
  logic [DATA_W-1:0] divisor = '0;
  logic [DATA_W-1:0] remainder;
  logic              done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  shiftsub_rem #(.DATA_W(DATA_W)) u_shiftsub_rem (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .dividend (dividend),
    .divisor  (divisor),
    .remainder(remainder),
    .done     (done)
  );

  function automatic int expRem(input int a, input int b);
    return (b == 0) ? a : (a % b);
  endfunction

  function automatic int expLat(input int b);
    int lz = 0;
    if (b == 0) return 1;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (b[i]) break;
      lz++;
    end
    return 3 * lz + 3;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Run one operation; optionally inject a second start mid-flight (R7)
  task automatic runOp(input int a, input int b, input bit inject, input int a2, input int b2);
    int lat;
    int held;
    @(negedge clk);
    dividend = a[DATA_W-1:0];
    divisor  = b[DATA_W-1:0];
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      if (inject && lat == 1) begin
        dividend = a2[DATA_W-1:0];
        divisor  = b2[DATA_W-1:0];
        start    = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    if (b == 0) begin
      check("R8", remainder, a, "zero divisor remainder");
      check("R8", lat, 1, "zero divisor latency");
    end else begin
      check(inject ? "R7" : "R2", remainder, expRem(a, b), $sformatf("%0d mod %0d", a, b));
      check(inject ? "R7" : "R3", lat, expLat(b), $sformatf("latency divisor %0d", b));
    end
    held = remainder;
    dividend = ~dividend;
    divisor  = divisor ^ 8'h5a;
    @(negedge clk);
    check("R5", done, 0, "done after one cycle");
    repeat (2) @(negedge clk);
    check("R6", remainder, held, "remainder held");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check("R1", done, 0, "reset done");
    check("R1", remainder, 0, "reset remainder");
    rstN = 1'b1;

    // Directed corners: restore with many leading zeros, equal operands, extremes
    runOp(0, 1, 0, 0, 0);
    runOp(255, 1, 0, 0, 0);
    runOp(2, 3, 0, 0, 0);
    runOp(7, 5, 0, 0, 0);
    runOp(24, 15, 0, 0, 0);
    runOp(200, 200, 0, 0, 0);
    runOp(255, 128, 0, 0, 0);
    runOp(127, 255, 0, 0, 0);
    runOp(254, 127, 0, 0, 0);
    runOp(99, 0, 0, 0, 0);      // R8
    runOp(0, 0, 0, 0, 0);       // R8

    // Busy start and operand changes ignored (R7)
    runOp(250, 3, 1, 17, 200);
    runOp(100, 1, 1, 9, 0);

    // Every nonzero divisor with random and boundary dividends (R2, R3, R4)
    for (int b = 1; b < 256; b++) begin
      runOp($urandom_range(255, 0), b, 0, 0, 0);
      runOp(b - 1, b, 0, 0, 0);
      runOp(255, b, 0, 0, 0);
    end
    finish();
  end
endmodule